// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block lets a host run single commands against a small serial EEPROM that sits on three wires: a chip-select, a serial clock and one bidirectional data line. The host presents an operation code, an 8-bit byte address and an 8-bit data byte for one cycle. The controller serialises the command, gathers read data, and for the four write-type commands it waits until the device reports that it is ready again. While any of this is in progress the block shows busy, and a command offered during that time has no effect.

The wait for ready is bounded by a clock-count limit (`TMO_CLKS`, about 30 ms in the target system). When the limit runs out, the wait is abandoned and a sticky timeout flag is raised. Whenever the block leaves reset, and whenever the host asks for a reload, it also reads a marker byte and a six-byte station address from the bottom of the EEPROM. It raises a loaded flag only when the marker is valid and every address byte has been read.

The data pin is split into `ee_dout`, `ee_oe` and `ee_din`. A pad or a testbench combines them into one wire.

Top module: `ser_rom_cmd_ctrl`

## Requirements
- R1: After reset, busy is high while the block reads address 0. If that byte is 0xA5, the block reads addresses 1 to 6, placing address k in `station_addr[8k-1:8k-8]`, then sets `addr_loaded` as busy falls.
- R2: If the marker byte is not 0xA5, the load ends with `addr_loaded` low. `cmd_op`=5 (reload) clears `addr_loaded` when accepted and repeats the load.
- R3: The `cmd_op` codes are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all and 5 reload. Each frame is sent MSB first with `ee_cs` high and is sampled by the device on rising `ee_sck`. It carries a start bit 1, then a 2-bit opcode and 8 address bits. The opcode is 10 for read, 01 for write and 11 for erase. Erase-all and write-all send opcode 00, with address bits 10xxxxxx and 01xxxxxx respectively.
- R4: A read takes 8 data bits from `ee_din`, MSB first, into `rdata` with `ee_oe` low. A read never waits for ready and never times out.
- R5: Write and write-all send the 8 bits of `cmd_wdata` after the address, MSB first.
- R6: Busy rises after a command is accepted and falls when the block is idle again. A `cmd_valid` pulse while busy is high is ignored.
- R7: After a write-type frame, `ee_cs` drops for one divider period and then rises for the ready poll with `ee_oe` low. The poll ends once `ee_din` reads high, with no timeout.
- R8: If `ee_din` stays low for `TMO_CLKS` clocks of the poll, the block drops `ee_cs`, returns to idle and sets `timed_out`.
- R9: With `ee_din` held high (no device), a write-type command ends within 3 clocks of the poll starting, and `timed_out` stays low.
- R10: `timed_out` stays set until `tmo_clr` is high for a cycle. Later successful commands do not clear it.
- R11: `ee_cs` and `ee_sck` are low whenever busy is low. Within a frame, rising edges of `ee_sck` are exactly 2*`CLK_DIV` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Operation code (R3) |
| cmd_addr | input | 8 | Byte address |
| cmd_wdata | input | 8 | Data to write |
| tmo_clr | input | 1 | Clears the timeout flag |
| busy | output | 1 | Command or load in progress |
| timed_out | output | 1 | Sticky ready-poll timeout |
| rdata | output | 8 | Last byte read by the host |
| addr_loaded | output | 1 | Station address valid |
| station_addr | output | 8*STA_BYTES | Loaded station address |
| ee_cs | output | 1 | Serial chip-select |
| ee_sck | output | 1 | Serial clock |
| ee_dout | output | 1 | Data pin output value |
| ee_oe | output | 1 | Data pin output enable |
| ee_din | input | 1 | Data pin input value |

## Verification
The hardest state to reach from the ports is a ready poll that runs to its limit. The device has to accept a full write frame and then hold the data line low for the whole window. The bench's device model has a pin mode that grounds the line after a normal frame, and `TMO_CLKS` is made small. This lets the bench count the clocks the poll lasts and compare the count with the limit. The same pin mode, plus a pulled-high mode, shows that a read is never bounded by the timer and that an absent device ends a write-type command at once.

// File: rtl/ser_rom_pkg.sv
package ser_rom_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int HDR_BITS = 3 + ADDR_W;
  localparam int FRAME_W  = HDR_BITS + DATA_W;
  localparam logic [DATA_W-1:0] MARKER = 8'hA5;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_ERASE  = 3'd2,
    OP_ERAL   = 3'd3,
    OP_WRAL   = 3'd4,
    OP_RELOAD = 3'd5
  } host_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP, ST_POLL
  } ctl_state_e;

  function automatic logic [FRAME_W-1:0] make_frame(host_op_e op, logic [ADDR_W-1:0] a,
                                                    logic [DATA_W-1:0] d);
    case (op)
      OP_READ:  return {3'b110, a, {DATA_W{1'b0}}};
      OP_WRITE: return {3'b101, a, d};
      OP_ERASE: return {3'b111, a, {DATA_W{1'b0}}};
      OP_ERAL:  return {3'b100, 2'b10, a[ADDR_W-3:0], {DATA_W{1'b0}}};
      OP_WRAL:  return {3'b100, 2'b01, a[ADDR_W-3:0], d};
      default:  return '0;
    endcase
  endfunction

  function automatic logic [4:0] frame_bits(host_op_e op);
    if (op == OP_READ || op == OP_WRITE || op == OP_WRAL) return 5'(FRAME_W);
    return 5'(HDR_BITS);
  endfunction

  function automatic logic is_wr_class(host_op_e op);
    return op inside {OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL};
  endfunction
endpackage

// File: rtl/ser_rom_tick.sv
module ser_rom_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(DIV - 1));
      if (cnt == CW'(DIV - 1)) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R11
endmodule

// File: rtl/ser_rom_sync.sv
module ser_rom_sync (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ser_rom_timer.sv
module ser_rom_timer #(
  parameter int LIMIT = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] cnt;

  assign expired = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(LIMIT - 1)); // R8
endmodule

// File: rtl/ser_rom_cmd_ctrl.sv
module ser_rom_cmd_ctrl
  import ser_rom_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int TMO_CLKS  = 3_000_000,
  parameter int STA_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [7:0]             cmd_addr,
  input  logic [7:0]             cmd_wdata,
  input  logic                   tmo_clr,
  output logic                   busy,
  output logic                   timed_out,
  output logic [7:0]             rdata,
  output logic                   addr_loaded,
  output logic [8*STA_BYTES-1:0] station_addr,
  output logic                   ee_cs,
  output logic                   ee_sck,
  output logic                   ee_dout,
  output logic                   ee_oe,
  input  logic                   ee_din
);
  localparam int LDW = $clog2(STA_BYTES + 1);

  ctl_state_e         state;
  host_op_e           cur_op;
  logic               autol;
  logic [LDW-1:0]     ld_idx;
  logic [FRAME_W-1:0] frame_sr;
  logic [4:0]         bit_cnt, nbits;
  logic [DATA_W-1:0]  in_sr;
  logic               tick, din_s, tmr_done, tmo_set;

  ser_rom_tick #(.DIV(CLK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));
  ser_rom_sync u_sync (.clk(clk), .rst(rst), .d(ee_din), .q(din_s));
  ser_rom_timer #(.LIMIT(TMO_CLKS)) u_tmr (
    .clk(clk), .rst(rst), .run(state == ST_POLL), .expired(tmr_done));

  assign busy    = (state != ST_IDLE);
  assign tmo_set = (state == ST_POLL) && !din_s && tmr_done;

  always_ff @(posedge clk) begin
    if (rst)          timed_out <= 1'b0;
    else if (tmo_set) timed_out <= 1'b1;
    else if (tmo_clr) timed_out <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_LOAD;
      cur_op       <= OP_READ;
      autol        <= 1'b1;
      ld_idx       <= '0;
      addr_loaded  <= 1'b0;
      station_addr <= '0;
      rdata        <= '0;
      frame_sr     <= '0;
      bit_cnt      <= '0;
      nbits        <= '0;
      in_sr        <= '0;
      ee_cs        <= 1'b0;
      ee_sck       <= 1'b0;
      ee_dout      <= 1'b0;
      ee_oe        <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_valid && cmd_op == 3'(OP_RELOAD)) begin
            autol       <= 1'b1;
            ld_idx      <= '0;
            addr_loaded <= 1'b0;
            state       <= ST_LOAD;
          end else if (cmd_valid && cmd_op < 3'(OP_RELOAD)) begin
            cur_op   <= host_op_e'(cmd_op);
            frame_sr <= make_frame(host_op_e'(cmd_op), cmd_addr, cmd_wdata);
            nbits    <= frame_bits(host_op_e'(cmd_op));
            bit_cnt  <= '0;
            ee_cs    <= 1'b1;
            ee_dout  <= 1'b1;
            ee_oe    <= 1'b1;
            state    <= ST_SHIFT;
          end
        end
        ST_LOAD: begin
          cur_op   <= OP_READ;
          frame_sr <= make_frame(OP_READ, 8'(ld_idx), '0);
          nbits    <= frame_bits(OP_READ);
          bit_cnt  <= '0;
          ee_cs    <= 1'b1;
          ee_dout  <= 1'b1;
          ee_oe    <= 1'b1;
          state    <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!ee_sck) begin
              ee_sck <= 1'b1;
              if (cur_op == OP_READ && bit_cnt >= 5'(HDR_BITS))
                in_sr <= {in_sr[DATA_W-2:0], din_s};
            end else if (bit_cnt == nbits - 5'd1) begin
              ee_sck  <= 1'b0;
              ee_cs   <= 1'b0;
              ee_oe   <= 1'b0;
              ee_dout <= 1'b0;
              state   <= ST_GAP;
            end else begin
              ee_sck   <= 1'b0;
              bit_cnt  <= bit_cnt + 5'd1;
              frame_sr <= frame_sr << 1;
              ee_dout  <= frame_sr[FRAME_W-2];
              ee_oe    <= !(cur_op == OP_READ && bit_cnt + 5'd1 >= 5'(HDR_BITS));
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (is_wr_class(cur_op)) begin
              ee_cs <= 1'b1;
              state <= ST_POLL;
            end else if (autol) begin
              if (ld_idx == '0) begin
                if (in_sr == MARKER) begin
                  ld_idx <= LDW'(1);
                  state  <= ST_LOAD;
                end else begin
                  autol <= 1'b0;
                  state <= ST_IDLE;
                end
              end else begin
                station_addr[(int'(ld_idx) - 1) * 8 +: 8] <= in_sr;
                if (ld_idx == LDW'(STA_BYTES)) begin
                  addr_loaded <= 1'b1;
                  autol       <= 1'b0;
                  state       <= ST_IDLE;
                end else begin
                  ld_idx <= ld_idx + 1'b1;
                  state  <= ST_LOAD;
                end
              end
            end else begin
              rdata <= in_sr;
              state <= ST_IDLE;
            end
          end
        end
        ST_POLL: begin
          if (din_s || tmr_done) begin
            ee_cs <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ee_cs && !ee_sck)); // R11
  AST_POLL_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL) |-> (ee_cs && !ee_oe)); // R7
  AST_LOADED_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_loaded) |-> !busy); // R1
  AST_TMO_FROM_POLL: assert property (@(posedge clk) disable iff (rst)
    $rose(timed_out) |-> ($past(state == ST_POLL) && !busy && !ee_cs)); // R8
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (timed_out && !tmo_clr) |=> timed_out); // R10
  AST_READ_OE_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && cur_op == OP_READ && bit_cnt >= 5'(HDR_BITS)) |-> !ee_oe); // R4
endmodule

// File: tb/ser_rom_cmd_ctrl_tb.sv
module ser_rom_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int TMO   = 300;
  localparam int NSTA  = 6;
  localparam int WBUSY = 80;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, tmo_clr = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic busy, timed_out, addr_loaded, ee_cs, ee_sck, ee_dout, ee_oe, ee_din;
  logic [7:0] rdata;
  logic [8*NSTA-1:0] station_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_rom_cmd_ctrl #(.CLK_DIV(DIV), .TMO_CLKS(TMO), .STA_BYTES(NSTA)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .tmo_clr(tmo_clr), .busy(busy), .timed_out(timed_out),
    .rdata(rdata), .addr_loaded(addr_loaded), .station_addr(station_addr),
    .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_dout(ee_dout), .ee_oe(ee_oe), .ee_din(ee_din));

  // ---------------- device model ----------------
  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [10:0] hdr = '0, last_hdr = '0;
  logic [7:0]  wd = '0, rd_sh = '0;
  logic        dev_out = 1'b1;
  int          nb = 0;
  int          clk_ctr = 0, wb_until = 0;
  int          pin_mode = 0;   // 0 device, 1 pulled high, 2 stuck low
  logic        rd_phase, dev_pin;

  assign rd_phase = ee_cs && (hdr[9:8] == 2'b10) && (nb >= 11);
  assign dev_pin  = rd_phase ? dev_out : (clk_ctr >= wb_until);
  assign ee_din   = ee_oe ? ee_dout : (pin_mode == 1) ? 1'b1 : (pin_mode == 2) ? 1'b0 : dev_pin;

  always @(posedge ee_sck or negedge ee_cs) begin
    if (!ee_cs) begin
      if (nb >= 11) last_hdr = hdr;
      if (nb == 19 && hdr[9:8] == 2'b01) mem[hdr[7:0]] = wd;
      if (nb == 19 && hdr[9:8] == 2'b00 && hdr[7:6] == 2'b01)
        for (int i = 0; i < 256; i++) mem[i] = wd;
      if (nb == 11 && hdr[9:8] == 2'b11) mem[hdr[7:0]] = 8'hFF;
      if (nb == 11 && hdr[9:8] == 2'b00 && hdr[7:6] == 2'b10)
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
      if (nb >= 11 && hdr[9:8] != 2'b10) wb_until = clk_ctr + WBUSY;
      nb = 0;
    end else if (nb < 11) begin
      hdr = {hdr[9:0], ee_dout};
      nb++;
      if (nb == 11 && hdr[9:8] == 2'b10) begin
        rd_sh = mem[hdr[7:0]];
        dev_out = rd_sh[7];
        rd_sh = rd_sh << 1;
      end
    end else begin
      if (hdr[9:8] == 2'b10) begin
        dev_out = rd_sh[7];
        rd_sh = rd_sh << 1;
      end else wd = {wd[6:0], ee_dout};
      nb++;
    end
  end

  // ---------------- monitors ----------------
  logic sck_prev = 1'b0, have_rise = 1'b0;
  int last_rise = 0, bad_period = 0, idle_bad = 0, poll_cnt = 0, rise_cnt = 0;
  always @(negedge clk) begin
    clk_ctr++;
    if (!rst) begin
      if (!busy && (ee_cs || ee_sck)) idle_bad++;
      if (ee_cs && !ee_oe && !rd_phase) poll_cnt++;
      if (!ee_cs) have_rise = 1'b0;
      if (ee_cs && ee_sck && !sck_prev) begin
        if (have_rise && (clk_ctr - last_rise != 2*DIV)) bad_period++;
        last_rise = clk_ctr;
        have_rise = 1'b1;
        rise_cnt++;
      end
    end
    sck_prev = ee_sck;
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic run_cmd(input int op, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    poll_cnt = 0;
    cmd_op = 3'(op); cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic apply_model(input int op, input logic [7:0] a, input logic [7:0] d);
    case (op)
      1: exp_mem[a] = d;
      2: exp_mem[a] = 8'hFF;
      3: for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
      4: for (int i = 0; i < 256; i++) exp_mem[i] = d;
      default: ;
    endcase
  endtask

  task automatic check_station(input string req);
    for (int k = 1; k <= NSTA; k++)
      chk(station_addr[8*(k-1) +: 8] == exp_mem[k], req, "station byte",
          station_addr[8*(k-1) +: 8], exp_mem[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 29 + 5) ^ 8'h5C);
      exp_mem[i] = mem[i];
    end
    mem[0] = 8'hA5; exp_mem[0] = 8'hA5;
    repeat (4) @(negedge clk);
    // reset state (autoload pending: busy high, flags low, bus quiet)
    chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
    chk(addr_loaded == 1'b0 && timed_out == 1'b0, "R10", "flags in reset",
        {addr_loaded, timed_out}, 0);
    chk(ee_cs == 1'b0 && ee_sck == 1'b0, "R11", "bus in reset", {ee_cs, ee_sck}, 0);
    rst = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    chk(addr_loaded == 1'b1, "R1", "loaded after autoload", addr_loaded, 1);
    check_station("R1");

    // read sweep
    for (int a = 0; a < 256; a += 7) begin
      run_cmd(0, 8'(a), 8'h00);
      chk(rdata == exp_mem[a], "R4", "read sweep", rdata, exp_mem[a]);
    end
    run_cmd(0, 8'h3C, 8'h00);
    chk(last_hdr == {1'b1, 2'b10, 8'h3C}, "R3", "read header", last_hdr, {1'b1, 2'b10, 8'h3C});

    // write sweep then readback
    for (int a = 1; a < 256; a += 3) begin
      run_cmd(1, 8'(a), 8'((a * 13 + 7)));
      apply_model(1, 8'(a), 8'((a * 13 + 7)));
      chk(mem[a] == exp_mem[a], "R5", "device after write", mem[a], exp_mem[a]);
      chk(timed_out == 1'b0, "R7", "no timeout with ready device", timed_out, 0);
    end
    chk(last_hdr[10:8] == 3'b101, "R3", "write header", last_hdr[10:8], 3'b101);
    for (int a = 1; a < 256; a += 3) begin
      run_cmd(0, 8'(a), 8'h00);
      chk(rdata == exp_mem[a], "R5", "write readback", rdata, exp_mem[a]);
    end

    // erase one
    run_cmd(2, 8'h21, 8'h00); apply_model(2, 8'h21, 8'h00);
    chk(last_hdr == {1'b1, 2'b11, 8'h21}, "R3", "erase header", last_hdr, {1'b1, 2'b11, 8'h21});
    run_cmd(0, 8'h21, 8'h00);
    chk(rdata == 8'hFF, "R3", "erased byte", rdata, 8'hFF);

    // command while busy is ignored
    run_cmd(1, 8'h20, 8'h77); apply_model(1, 8'h20, 8'h77);
    @(negedge clk);
    cmd_op = 3'd1; cmd_addr = 8'h10; cmd_wdata = 8'h11; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R6", "busy after accept", busy, 1);
    cmd_op = 3'd1; cmd_addr = 8'h20; cmd_wdata = 8'h22; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    apply_model(1, 8'h10, 8'h11);
    run_cmd(0, 8'h20, 8'h00);
    chk(rdata == 8'h77, "R6", "ignored write left byte", rdata, 8'h77);
    run_cmd(0, 8'h10, 8'h00);
    chk(rdata == 8'h11, "R6", "accepted write", rdata, 8'h11);

    // ready poll timeout
    pin_mode = 2;
    run_cmd(1, 8'h40, 8'h99); apply_model(1, 8'h40, 8'h99);
    chk(timed_out == 1'b1, "R8", "timeout flag", timed_out, 1);
    chk(poll_cnt == TMO, "R8", "poll length", poll_cnt, TMO);
    chk(ee_cs == 1'b0, "R8", "cs dropped", ee_cs, 0);
    run_cmd(0, 8'h41, 8'h00);
    chk(rdata == 8'h00, "R4", "read with line low", rdata, 0);
    pin_mode = 0;
    run_cmd(0, 8'h40, 8'h00);
    chk(timed_out == 1'b1, "R10", "sticky over success", timed_out, 1);
    chk(rdata == 8'h99, "R5", "write before timeout", rdata, 8'h99);
    @(negedge clk); tmo_clr = 1'b1; @(negedge clk); tmo_clr = 1'b0;
    chk(timed_out == 1'b0, "R10", "cleared by tmo_clr", timed_out, 0);

    // read never times out, line stuck low
    pin_mode = 2;
    run_cmd(0, 8'h05, 8'h00);
    chk(timed_out == 1'b0, "R4", "read no timeout", timed_out, 0);

    // absent device, pulled high
    pin_mode = 1;
    run_cmd(2, 8'h41, 8'h00); apply_model(2, 8'h41, 8'h00);
    chk(timed_out == 1'b0, "R9", "no timeout pulled high", timed_out, 0);
    chk(poll_cnt <= 3 && poll_cnt >= 1, "R9", "short poll", poll_cnt, 1);
    pin_mode = 0;

    // erase all / write all
    run_cmd(3, 8'h00, 8'h00); apply_model(3, 8'h00, 8'h00);
    chk(last_hdr[10:6] == 5'b10010, "R3", "erase-all header", last_hdr[10:6], 5'b10010);
    for (int a = 0; a < 256; a += 51) begin
      run_cmd(0, 8'(a), 8'h00);
      chk(rdata == 8'hFF, "R3", "erase-all byte", rdata, 8'hFF);
    end
    run_cmd(4, 8'hFF, 8'h3C); apply_model(4, 8'h00, 8'h3C);
    chk(last_hdr[10:6] == 5'b10001, "R3", "write-all header", last_hdr[10:6], 5'b10001);
    for (int a = 0; a < 256; a += 51) begin
      run_cmd(0, 8'(a), 8'h00);
      chk(rdata == 8'h3C, "R5", "write-all byte", rdata, 8'h3C);
    end

    // reload with bad marker, then good
    @(negedge clk);
    cmd_op = 3'd5; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(addr_loaded == 1'b0, "R2", "loaded cleared on reload", addr_loaded, 0);
    while (busy) @(negedge clk);
    chk(addr_loaded == 1'b0, "R2", "bad marker", addr_loaded, 0);
    run_cmd(1, 8'h00, 8'hA5); apply_model(1, 8'h00, 8'hA5);
    for (int k = 1; k <= NSTA; k++) begin
      run_cmd(1, 8'(k), 8'(8'hC0 + k * 3)); apply_model(1, 8'(k), 8'(8'hC0 + k * 3));
    end
    run_cmd(5, 8'h00, 8'h00);
    chk(addr_loaded == 1'b1, "R2", "reload good marker", addr_loaded, 1);
    check_station("R2");

    chk(rise_cnt > 0 && bad_period == 0, "R11", "sck period", bad_period, 0);
    chk(idle_bad == 0, "R11", "bus quiet when idle", idle_bad, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule